// File: doc/BRIEF.md
# Burst Double-Rate SRAM Control Front-End

This block is the synchronous control path of a pipelined double-rate burst SRAM. It runs on one core clock and handles each double-rate beat pair as two words per cycle. The `rise` word stands for the beat on the main clock's rising edge and the `fall` word for the beat on the complementary edge. An active-low load strobe and a read/write strobe start a burst. The burst covers four words of an aligned group, taken in linear order from the starting word given by the low address bits. It therefore takes exactly two core cycles.

Writes are late writes. A write burst's words are held in a four-word buffer, and the array is not updated until the next write burst is accepted. Reads look in that buffer word by word, so a read that follows a write sees the newest data at once and without a dead cycle. Read data comes out one cycle after each beat cycle, with a valid flag. An output-drive enable models the data bus driver: it turns on with read data, holds across write cycles, and turns off one cycle after an idle cycle.

Top module: `ddr_burst_frontend`

## Requirements
- R1: While reset is asserted and right after it is released, `rvalid`, `drv_en`, `rdata_rise` and `rdata_fall` are all 0, and no write is pending.
- R2: A burst is accepted when `load_n` is 0 and no burst is in progress. `rd_wr_n`=1 selects a read and `rd_wr_n`=0 a write. An accepted burst occupies that cycle and exactly one more. A write burst produces no read data.
- R3: `addr[1:0]` is the starting word s and `addr[AW-1:2]` is the group. The first cycle carries word offsets s (rise) and s+1 (fall). The second cycle carries s+2 (rise) and s+3 (fall). All offsets are taken modulo 4, and the group is fixed for the whole burst.
- R4: In both cycles of a write burst, `wdata_rise` and `wdata_fall` are captured as the words at that cycle's rise and fall offsets.
- R5: For each read beat cycle, `rdata_rise`/`rdata_fall` hold that cycle's two words, and `rvalid`=1 in the following cycle. In any other cycle, `rvalid` is 0 one cycle later.
- R6: A completed write burst stays pending in the buffer until the next write burst is accepted, and at that point it is committed to the array. A read returns the buffered word for each offset whose pending word belongs to the same group, and the array word otherwise.
- R7: A read burst may be loaded in the cycle right after the second cycle of a write burst, and it returns that write's data.
- R8: A load presented during the second cycle of a burst is ignored. A read load there yields no `rvalid`, and a write load there changes no stored data.
- R9: `drv_en` becomes 1 after any read beat cycle. It becomes 0 after an idle cycle (`load_n`=1 with no burst in progress). It keeps its value across write beat cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_n | input | 1 | Active-low burst load strobe |
| rd_wr_n | input | 1 | 1 = read, 0 = write, sampled with the load |
| addr | input | AW | Word address; low two bits give the starting word |
| wdata_rise | input | DW | Write word for the rising-edge beat |
| wdata_fall | input | DW | Write word for the falling-edge beat |
| rdata_rise | output | DW | Read word for the rising-edge beat |
| rdata_fall | output | DW | Read word for the falling-edge beat |
| rvalid | output | 1 | Read data valid |
| drv_en | output | 1 | Data bus driver enable |

## Verification
The assertions assume that reset is applied before the first load and that `load_n` and `rd_wr_n` are never unknown at a clock edge outside reset. Under those assumptions, the burst length, the read latency and the driver-enable rules follow from the strobes alone. The stimulus changes inputs only on the falling clock edge and keeps every strobe at a defined value. It reads only groups that it has written before, so every expected word comes from the bench's own shadow copy. The second cycle of some bursts deliberately carries a load, to exercise the ignore rule.

// File: rtl/ddrf_pkg.sv
package ddrf_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RD2  = 2'd1,
    PH_WR2  = 2'd2
  } phase_t;

  localparam int unsigned BEATS = 4;

  // linear step inside an aligned group of four words
  function automatic logic [1:0] beat_step(input logic [1:0] base, input logic [1:0] k);
    return base + k;
  endfunction

endpackage

// File: rtl/ddrf_burst_seq.sv
module ddrf_burst_seq
  import ddrf_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_n,
  input  logic          rd_wr_n,
  input  logic [AW-1:0] addr,
  output logic          rd_beat,
  output logic          wr_beat,
  output logic          wr_start,
  output logic          nop,
  output logic [AW-3:0] grp,
  output logic [1:0]    off_r,
  output logic [1:0]    off_f
);

  phase_t        ph_q, ph_d;
  logic [1:0]    nxt_q, nxt_d;
  logic [AW-3:0] grp_q, grp_d;
  logic          accept;
  logic          busy;

  assign busy   = (ph_q != PH_IDLE);
  assign accept = !load_n && !busy;

  always_comb begin
    ph_d  = ph_q;
    nxt_d = nxt_q;
    grp_d = grp_q;
    if (accept) begin
      ph_d  = rd_wr_n ? PH_RD2 : PH_WR2;
      nxt_d = beat_step(addr[1:0], 2'd2);
      grp_d = addr[AW-1:2];
    end else if (busy) begin
      ph_d = PH_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      nxt_q <= '0;
      grp_q <= '0;
    end else begin
      ph_q <= ph_d;
      if (accept) begin
        nxt_q <= nxt_d;
        grp_q <= grp_d;
      end
    end
  end

  assign rd_beat  = (accept && rd_wr_n) || (ph_q == PH_RD2);
  assign wr_beat  = (accept && !rd_wr_n) || (ph_q == PH_WR2);
  assign wr_start = accept && !rd_wr_n;
  assign nop      = !busy && load_n;
  assign grp      = busy ? grp_q : addr[AW-1:2];
  assign off_r    = busy ? nxt_q : addr[1:0];
  assign off_f    = beat_step(off_r, 2'd1);

endmodule

// File: rtl/ddrf_late_wbuf.sv
module ddrf_late_wbuf
  import ddrf_pkg::*;
#(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 36
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_start,
  input  logic                       wr_beat,
  input  logic [AW-3:0]              grp,
  input  logic [1:0]                 off_r,
  input  logic [1:0]                 off_f,
  input  logic [DW-1:0]              wd_r,
  input  logic [DW-1:0]              wd_f,
  output logic                       commit_en,
  output logic [AW-3:0]              commit_grp,
  output logic [BEATS-1:0]           commit_mask,
  output logic [BEATS-1:0][DW-1:0]   commit_data,
  output logic                       hit_r,
  output logic                       hit_f,
  output logic [DW-1:0]              fwd_r,
  output logic [DW-1:0]              fwd_f
);

  logic [BEATS-1:0]         val_q, val_d;
  logic [AW-3:0]            grp_q, grp_d;
  logic [BEATS-1:0][DW-1:0] words_q, words_d;

  always_comb begin
    val_d   = val_q;
    grp_d   = grp_q;
    words_d = words_q;
    if (wr_start) begin
      val_d = '0;
      grp_d = grp;
    end
    if (wr_beat) begin
      val_d[off_r]   = 1'b1;
      val_d[off_f]   = 1'b1;
      words_d[off_r] = wd_r;
      words_d[off_f] = wd_f;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      grp_q <= '0;
    end else begin
      if (wr_beat) begin
        val_q <= val_d;
        grp_q <= grp_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_beat) begin
      words_q <= words_d;
    end
  end

  // the pending burst drains to the array when the next write begins
  assign commit_en   = wr_start && (|val_q);
  assign commit_grp  = grp_q;
  assign commit_mask = val_q;
  assign commit_data = words_q;

  // per-word lookup for reads
  assign hit_r = val_q[off_r] && (grp_q == grp);
  assign hit_f = val_q[off_f] && (grp_q == grp);
  assign fwd_r = words_q[off_r];
  assign fwd_f = words_q[off_f];

endmodule

// File: rtl/ddrf_word_array.sv
module ddrf_word_array
  import ddrf_pkg::*;
#(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 36
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [AW-3:0]            wgrp,
  input  logic [BEATS-1:0]         wmask,
  input  logic [BEATS-1:0][DW-1:0] wdata,
  input  logic [AW-3:0]            rgrp,
  input  logic [1:0]               roff_r,
  input  logic [1:0]               roff_f,
  output logic [DW-1:0]            rd_r,
  output logic [DW-1:0]            rd_f
);

  localparam int unsigned GROUPS = 1 << (AW - 2);

  logic [DW-1:0] lane [BEATS];

  // one bank per word offset so a whole group commits in one cycle
  for (genvar b = 0; b < BEATS; b++) begin : g_bank
    logic [DW-1:0] mem [GROUPS];

    always_ff @(posedge clk) begin
      if (we && wmask[b]) begin
        mem[wgrp] <= wdata[b];
      end
    end

    assign lane[b] = mem[rgrp];
  end

  assign rd_r = lane[roff_r];
  assign rd_f = lane[roff_f];

endmodule

// File: rtl/ddrf_read_port.sv
module ddrf_read_port #(
  parameter int unsigned DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_beat,
  input  logic          nop,
  input  logic          hit_r,
  input  logic          hit_f,
  input  logic [DW-1:0] fwd_r,
  input  logic [DW-1:0] fwd_f,
  input  logic [DW-1:0] arr_r,
  input  logic [DW-1:0] arr_f,
  output logic [DW-1:0] rdata_r,
  output logic [DW-1:0] rdata_f,
  output logic          rvalid,
  output logic          drv_en
);

  logic [DW-1:0] sel_r, sel_f;
  logic          drv_d;

  assign sel_r = hit_r ? fwd_r : arr_r;
  assign sel_f = hit_f ? fwd_f : arr_f;

  always_comb begin
    drv_d = drv_en;
    if (rd_beat) begin
      drv_d = 1'b1;
    end else if (nop) begin
      drv_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_r <= '0;
      rdata_f <= '0;
      rvalid  <= 1'b0;
      drv_en  <= 1'b0;
    end else begin
      rvalid <= rd_beat;
      drv_en <= drv_d;
      if (rd_beat) begin
        rdata_r <= sel_r;
        rdata_f <= sel_f;
      end
    end
  end

endmodule

// File: rtl/ddr_burst_frontend.sv
module ddr_burst_frontend
  import ddrf_pkg::*;
#(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_n,
  input  logic          rd_wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata_rise,
  input  logic [DW-1:0] wdata_fall,
  output logic [DW-1:0] rdata_rise,
  output logic [DW-1:0] rdata_fall,
  output logic          rvalid,
  output logic          drv_en
);

  logic                     rd_beat, wr_beat, wr_start, nop;
  logic [AW-3:0]            grp;
  logic [1:0]               off_r, off_f;
  logic                     commit_en;
  logic [AW-3:0]            commit_grp;
  logic [BEATS-1:0]         commit_mask;
  logic [BEATS-1:0][DW-1:0] commit_data;
  logic                     hit_r, hit_f;
  logic [DW-1:0]            fwd_r, fwd_f, arr_r, arr_f;

  ddrf_burst_seq #(.AW(AW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_n   (load_n),
    .rd_wr_n  (rd_wr_n),
    .addr     (addr),
    .rd_beat  (rd_beat),
    .wr_beat  (wr_beat),
    .wr_start (wr_start),
    .nop      (nop),
    .grp      (grp),
    .off_r    (off_r),
    .off_f    (off_f)
  );

  ddrf_late_wbuf #(.AW(AW), .DW(DW)) u_wbuf (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_start    (wr_start),
    .wr_beat     (wr_beat),
    .grp         (grp),
    .off_r       (off_r),
    .off_f       (off_f),
    .wd_r        (wdata_rise),
    .wd_f        (wdata_fall),
    .commit_en   (commit_en),
    .commit_grp  (commit_grp),
    .commit_mask (commit_mask),
    .commit_data (commit_data),
    .hit_r       (hit_r),
    .hit_f       (hit_f),
    .fwd_r       (fwd_r),
    .fwd_f       (fwd_f)
  );

  ddrf_word_array #(.AW(AW), .DW(DW)) u_array (
    .clk    (clk),
    .we     (commit_en),
    .wgrp   (commit_grp),
    .wmask  (commit_mask),
    .wdata  (commit_data),
    .rgrp   (grp),
    .roff_r (off_r),
    .roff_f (off_f),
    .rd_r   (arr_r),
    .rd_f   (arr_f)
  );

  ddrf_read_port #(.DW(DW)) u_rport (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_beat (rd_beat),
    .nop     (nop),
    .hit_r   (hit_r),
    .hit_f   (hit_f),
    .fwd_r   (fwd_r),
    .fwd_f   (fwd_f),
    .arr_r   (arr_r),
    .arr_f   (arr_f),
    .rdata_r (rdata_rise),
    .rdata_f (rdata_fall),
    .rvalid  (rvalid),
    .drv_en  (drv_en)
  );

endmodule

// File: rtl/ddrf_checker.sv
module ddrf_checker (
  input logic clk,
  input logic rst_n,
  input logic rd_beat,
  input logic wr_beat,
  input logic wr_start,
  input logic nop,
  input logic rvalid,
  input logic drv_en
);

  assert_write_second_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> wr_beat);

  assert_single_direction_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_beat && wr_beat));

  assert_load_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> !rd_beat);

  assert_read_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_beat |=> rvalid);

  assert_idle_no_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    nop |=> !rvalid);

  assert_idle_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    nop |=> !drv_en);

  assert_valid_driven_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> drv_en);

  assert_write_holds_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> (drv_en == $past(drv_en)));

endmodule

bind ddr_burst_frontend ddrf_checker u_ddrf_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_beat  (rd_beat),
  .wr_beat  (wr_beat),
  .wr_start (wr_start),
  .nop      (nop),
  .rvalid   (rvalid),
  .drv_en   (drv_en)
);

// File: tb/test_ddr_burst_frontend.sv
module test_ddr_burst_frontend;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 36;
  localparam int GROUPS = 1 << (AW - 2);

  logic          clk;
  logic          rst_n;
  logic          load_n;
  logic          rd_wr_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata_rise, wdata_fall;
  logic [DW-1:0] rdata_rise, rdata_fall;
  logic          rvalid, drv_en;

  int total;
  int bad;
  bit done;
  logic [DW-1:0] model [1 << AW];

  ddr_burst_frontend #(.AW(AW), .DW(DW)) i_ddr_burst_frontend (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_n     (load_n),
    .rd_wr_n    (rd_wr_n),
    .addr       (addr),
    .wdata_rise (wdata_rise),
    .wdata_fall (wdata_fall),
    .rdata_rise (rdata_rise),
    .rdata_fall (rdata_fall),
    .rvalid     (rvalid),
    .drv_en     (drv_en)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [DW-1:0] pat(input int g, input int o, input int p);
    return 36'(g * 40503 + o * 2749 + p * 65537) ^ 36'hA5C39E17B;
  endfunction

  function automatic int wi(input int g, input int o);
    return g * 4 + (o % 4);
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R2 R3 R4: write burst; optional load during second cycle (R8), drive hold check (R9)
  task automatic write_burst(input int g, input int s, input int p, input bit intr, input bit hold);
    for (int o = 0; o < 4; o++) model[wi(g, o)] = pat(g, o, p);
    load_n = 1'b0; rd_wr_n = 1'b0; addr = AW'(g * 4 + s);
    wdata_rise = pat(g, s % 4, p); wdata_fall = pat(g, (s + 1) % 4, p);
    @(negedge clk);
    chk("R2 write gives no rvalid", {35'd0, rvalid}, 36'd0);
    if (hold) chk("R9 drv_en held over write", {35'd0, drv_en}, 36'd1);
    if (intr) begin
      load_n = 1'b0; rd_wr_n = 1'b1; addr = AW'(((g + 3) % GROUPS) * 4);
    end else begin
      load_n = 1'b1;
    end
    wdata_rise = pat(g, (s + 2) % 4, p); wdata_fall = pat(g, (s + 3) % 4, p);
    @(negedge clk);
    if (intr) chk("R8 read load in burst ignored", {35'd0, rvalid}, 36'd0);
    if (hold) chk("R9 drv_en held over write", {35'd0, drv_en}, 36'd1);
    load_n = 1'b1;
  endtask

  // R3 R5 R6: read burst; optional write load during second cycle (R8)
  task automatic read_burst(input int g, input int s, input string tag, input bit intr, input int ig);
    load_n = 1'b0; rd_wr_n = 1'b1; addr = AW'(g * 4 + s);
    @(negedge clk);
    chk({tag, " R5 rvalid pair0"}, {35'd0, rvalid}, 36'd1);
    chk({tag, " R3 rise pair0"}, rdata_rise, model[wi(g, s)]);
    chk({tag, " R3 fall pair0"}, rdata_fall, model[wi(g, s + 1)]);
    if (intr) begin
      load_n = 1'b0; rd_wr_n = 1'b0; addr = AW'(ig * 4);
      wdata_rise = 36'hDEADBEEF0; wdata_fall = 36'h0BADF00D1;
    end else begin
      load_n = 1'b1;
    end
    @(negedge clk);
    chk({tag, " R5 rvalid pair1"}, {35'd0, rvalid}, 36'd1);
    chk({tag, " R3 rise pair1"}, rdata_rise, model[wi(g, s + 2)]);
    chk({tag, " R3 fall pair1"}, rdata_fall, model[wi(g, s + 3)]);
    load_n = 1'b1;
  endtask

  task automatic idle_cyc();
    load_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    total = 0; bad = 0; done = 1'b0;
    rst_n = 1'b0; load_n = 1'b1; rd_wr_n = 1'b1; addr = '0;
    wdata_rise = '0; wdata_fall = '0;
    repeat (3) @(negedge clk);
    chk("R1 rvalid in reset", {35'd0, rvalid}, 36'd0);
    chk("R1 drv_en in reset", {35'd0, drv_en}, 36'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rvalid after reset", {35'd0, rvalid}, 36'd0);
    chk("R1 drv_en after reset", {35'd0, drv_en}, 36'd0);
    chk("R1 rdata_rise after reset", rdata_rise, 36'd0);
    chk("R1 rdata_fall after reset", rdata_fall, 36'd0);

    // R4: back-to-back write bursts over every group, all start offsets
    for (int g = 0; g < GROUPS; g++) write_burst(g, g % 4, 1, 1'b0, 1'b0);

    // R3 R6: every group, every start; last group still pending (forwarded)
    for (int g = 0; g < GROUPS; g++)
      for (int s = 0; s < 4; s++) read_burst(g, s, "sweep", 1'b0, 0);

    // R7: read straight after write to the same group
    write_burst(5, 2, 2, 1'b0, 1'b0);
    read_burst(5, 3, "R7 no dead cycle", 1'b0, 0);
    // R6: next write commits group 5; group 9 then pending
    write_burst(9, 1, 3, 1'b0, 1'b0);
    read_burst(5, 0, "R6 committed", 1'b0, 0);
    read_burst(9, 2, "R6 forwarded", 1'b0, 0);
    // R6: rewrite a committed-then-pending group, stale array must be hidden
    write_burst(9, 3, 4, 1'b0, 1'b0);
    read_burst(9, 1, "R6 newest data", 1'b0, 0);

    // R8: loads during the second cycle are ignored
    write_burst(3, 0, 5, 1'b1, 1'b0);
    read_burst(3, 1, "R8 after ignored read", 1'b0, 0);
    read_burst(2, 0, "R8 read with write load", 1'b1, 11);
    idle_cyc();
    read_burst(11, 2, "R8 group untouched", 1'b0, 0);
    write_burst(12, 0, 6, 1'b0, 1'b0);
    read_burst(11, 0, "R8 group untouched after commit", 1'b0, 0);

    // R9: driver enable behaviour
    idle_cyc();
    chk("R9 drv_en off after idle", {35'd0, drv_en}, 36'd0);
    read_burst(4, 0, "R9 read", 1'b0, 0);
    chk("R9 drv_en on after read", {35'd0, drv_en}, 36'd1);
    write_burst(6, 3, 7, 1'b0, 1'b1);
    chk("R5 no rvalid after write", {35'd0, rvalid}, 36'd0);
    idle_cyc();
    chk("R9 drv_en off after idle", {35'd0, drv_en}, 36'd0);
    chk("R5 no rvalid after idle", {35'd0, rvalid}, 36'd0);
    read_burst(6, 1, "R9 readback", 1'b0, 0);
    idle_cyc();
    chk("R9 drv_en off after read then idle", {35'd0, drv_en}, 36'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule